// File: doc/BRIEF.md
# Grouped unary, multiply and shift execution unit

This unit executes the register-direct forms of two instruction groups of a 32-bit integer core. In these groups the middle three bits of the operand-specifier byte pick the operation. Under group code 0xF7 the unit performs bitwise inversion, two's-complement negation and an unsigned widening multiply against the accumulator register. Under group code 0xD3 it performs a left shift, a logical right shift and an arithmetic right shift. In all three shifts the count comes from the low five bits of the count register.

The unit holds the eight-entry register file. The accumulator is index 0, the count register is index 1 and the high-product register is index 2. The unit also holds the sign, zero and overflow flags. Registers are preset through a load port and observed through a combinational read port. The inversion, negation and shifts finish in one cycle. The multiply runs one bit per cycle and signals `busy` while it works and `done` when it finishes. An operation that cannot be decoded raises `bad_op` and changes nothing.

Top module: `grp_unit`

## Requirements
- R1: After reset every register reads zero, the sign, zero and overflow flags are 0, and `busy`, `done` and `bad_op` are low.
- R2: Code 0xF7 with specifier bits [7:6]=3 and bits [5:3]=2 replaces register bits [2:0] with its bitwise inverse. The sign flag takes bit 31 of the result, the zero flag is set for a zero result, and overflow is cleared.
- R3: Code 0xF7 with bits [5:3]=3 replaces the register with its two's-complement negative, sets sign and zero from the result, and clears overflow.
- R4: Negating 0x80000000 leaves the register unchanged and sets sign=1, zero=0 and overflow=1.
- R5: Code 0xF7 with bits [5:3]=4 forms the unsigned 64-bit product of register 0 and the selected register, both captured at issue. The low half goes to register 0 and the high half to register 2. Overflow is set exactly when the high half is nonzero, and sign and zero are left unchanged. `busy` is high for exactly W cycles, and `done` pulses in the cycle after the last of them.
- R6: Code 0xD3 with bits [5:3]=4 shifts the register left by register 1 bits [4:0]. Sign and zero follow the result for every count, including zero.
- R7: Code 0xD3 with bits [5:3]=5 shifts right with zero fill, clears the sign flag and sets zero from the result.
- R8: Code 0xD3 with bits [5:3]=7 shifts right with the sign bit replicated, and sets sign and zero from the result.
- R9: A shift changes overflow only when the masked count is 1. In that case a left shift sets it to operand bit 31 XOR operand bit 30, a logical right shift sets it to operand bit 31, and an arithmetic right shift clears it.
- R10: Any other code, any other bits [5:3] value, or bits [7:6] not equal to 3 makes `bad_op` pulse high for one cycle. `done` stays low, and no register or flag changes.
- R11: `op_valid` while `busy` is high is ignored: no register or flag changes, and no extra `done` or `bad_op` pulse follows.
- R12: `ld_en` writes `ld_data` to register `ld_idx` at the clock edge, and `rd_data` shows register `rd_idx` combinationally.
- R13: A single-cycle operation issued with `op_valid` updates its register and flags at the next edge, and `done` is high for the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 3 | Register index to load |
| ld_data | input | W | Value to load |
| rd_idx | input | 3 | Register index to observe |
| rd_data | output | W | Contents of register `rd_idx` |
| op_valid | input | 1 | Issue an operation this cycle |
| op_code | input | 8 | Group code (0xF7 or 0xD3) |
| op_modrm | input | 8 | Operand-specifier byte: mode [7:6], selector [5:3], register [2:0] |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | Operation finished in the previous edge |
| bad_op | output | 1 | Undecodable operation rejected |
| sf | output | 1 | Sign flag |
| zf | output | 1 | Zero flag |
| of | output | 1 | Overflow flag |

## Verification
A bad value in the register file or the flags reaches the ports one cycle after the operation that caused it. The read port and the flag outputs are sampled right after every `done`, so a wrong result is seen before the next operation is issued. A fault in the multiply step counter or in the partial-product datapath becomes visible only at completion. It appears either as a `busy` window that is not exactly W cycles long, or as wrong contents in registers 0 and 2. Faults in the overflow rules for counts other than 1 persist silently. These are exposed by tracking the previous overflow value across shifts whose counts are not 1.

// File: rtl/grp_unit.sv
module grp_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [2:0]   ld_idx,
  input  logic [W-1:0] ld_data,
  input  logic [2:0]   rd_idx,
  output logic [W-1:0] rd_data,
  input  logic         op_valid,
  input  logic [7:0]   op_code,
  input  logic [7:0]   op_modrm,
  output logic         busy,
  output logic         done,
  output logic         bad_op,
  output logic         sf,
  output logic         zf,
  output logic         of
);
  localparam int NREG = 8;
  localparam int CW   = $clog2(W);
  localparam int KW   = $clog2(W + 1);
  localparam logic [2:0] ACC = 3'd0;
  localparam logic [2:0] CNT = 3'd1;
  localparam logic [2:0] HIR = 3'd2;
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  typedef enum logic [2:0] {K_BAD, K_NOT, K_NEG, K_MUL, K_SHL, K_SHR, K_SAR} kind_t;

  logic [W-1:0] rf [NREG];
  logic [W-1:0] mcand, plo, phi;
  logic [KW-1:0] step;

  wire [2:0]    sel  = op_modrm[5:3];
  wire [2:0]    rm   = op_modrm[2:0];
  wire [W-1:0]  opnd = rf[rm];
  wire [CW-1:0] amt  = rf[CNT][CW-1:0];

  kind_t kind;
  always_comb begin
    kind = K_BAD;
    if (op_modrm[7:6] == 2'b11) begin
      if (op_code == 8'hF7) begin
        case (sel)
          3'd2: kind = K_NOT;
          3'd3: kind = K_NEG;
          3'd4: kind = K_MUL;
          default: kind = K_BAD;
        endcase
      end else if (op_code == 8'hD3) begin
        case (sel)
          3'd4: kind = K_SHL;
          3'd5: kind = K_SHR;
          3'd7: kind = K_SAR;
          default: kind = K_BAD;
        endcase
      end
    end
  end

  wire [W-1:0] not_res = ~opnd;
  wire [W-1:0] neg_res = -opnd;
  wire [W-1:0] shl_res = opnd << amt;
  wire [W-1:0] shr_res = opnd >> amt;
  wire [W-1:0] sar_res = W'($signed(opnd) >>> amt);
  wire         amt_one = (amt == CW'(1));

  wire [W:0]     psum   = {1'b0, phi} + (plo[0] ? {1'b0, mcand} : {(W+1){1'b0}});
  wire [2*W-1:0] pnext  = {psum, plo[W-1:1]};
  wire           last   = (step == KW'(W - 1));

  assign rd_data = rf[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      mcand  <= '0;
      plo    <= '0;
      phi    <= '0;
      step   <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      bad_op <= 1'b0;
      sf     <= 1'b0;
      zf     <= 1'b0;
      of     <= 1'b0;
    end else begin
      done   <= 1'b0;
      bad_op <= 1'b0;
      if (ld_en) rf[ld_idx] <= ld_data;
      if (busy) begin
        phi  <= pnext[2*W-1:W];
        plo  <= pnext[W-1:0];
        step <= step + KW'(1);
        if (last) begin
          rf[ACC] <= pnext[W-1:0];
          rf[HIR] <= pnext[2*W-1:W];
          of      <= |pnext[2*W-1:W];
          busy    <= 1'b0;
          done    <= 1'b1;
        end
      end else if (op_valid) begin
        done <= (kind != K_BAD) && (kind != K_MUL);
        case (kind)
          K_NOT: begin
            rf[rm] <= not_res;
            sf <= not_res[W-1];
            zf <= (not_res == '0);
            of <= 1'b0;
          end
          K_NEG: begin
            if (opnd == MINV) begin
              sf <= 1'b1;
              zf <= 1'b0;
              of <= 1'b1;
            end else begin
              rf[rm] <= neg_res;
              sf <= neg_res[W-1];
              zf <= (neg_res == '0);
              of <= 1'b0;
            end
          end
          K_MUL: begin
            mcand <= rf[ACC];
            plo   <= opnd;
            phi   <= '0;
            step  <= '0;
            busy  <= 1'b1;
          end
          K_SHL: begin
            rf[rm] <= shl_res;
            sf <= shl_res[W-1];
            zf <= (shl_res == '0);
            if (amt_one) of <= opnd[W-1] ^ opnd[W-2];
          end
          K_SHR: begin
            rf[rm] <= shr_res;
            sf <= 1'b0;
            zf <= (shr_res == '0);
            if (amt_one) of <= opnd[W-1];
          end
          K_SAR: begin
            rf[rm] <= sar_res;
            sf <= sar_res[W-1];
            zf <= (sar_res == '0);
            if (amt_one) of <= 1'b0;
          end
          default: bad_op <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/grp_unit_chk.sv
module grp_unit_chk #(
  parameter int W = 32
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic bad_op,
  input logic sf,
  input logic zf,
  input logic of
);
  logic [15:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n) run_len <= '0;
    else if (busy) run_len <= run_len + 16'd1;
    else run_len <= '0;
  end

  a_r10_reject_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && bad_op));

  a_r10_reject_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> ($stable(sf) && $stable(zf) && $stable(of)));

  a_r5_end_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= 16'(W));

  a_r5_of_held_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($stable(of) && $stable(sf) && $stable(zf)));

  a_r4_sign_zero_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sf && zf));

  a_r11_no_done_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!done && !bad_op));
endmodule

bind grp_unit grp_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .bad_op(bad_op), .sf(sf), .zf(zf), .of(of)
);

// File: tb/sim_grp_unit.sv
`timescale 1ns/1ps
module sim_grp_unit;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic [2:0] ld_idx = '0, rd_idx = '0;
  logic [W-1:0] ld_data = '0, rd_data;
  logic op_valid = 1'b0;
  logic [7:0] op_code = '0, op_modrm = '0;
  logic busy, done, bad_op, sf, zf, of;

  grp_unit #(.W(W)) u0 (.*);

  always #4 clk = ~clk;

  int nvec = 0, nbad = 0;
  logic [W-1:0] m [8];
  logic msf = 0, mzf = 0, mof = 0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i);
      #1;
      chk(req, rd_data, m[i]);
    end
  endtask

  task automatic chk_flags(input string req);
    chk({req, " sf"}, W'(sf), W'(msf));
    chk({req, " zf"}, W'(zf), W'(mzf));
    chk({req, " of"}, W'(of), W'(mof));
  endtask

  task automatic load(input int idx, input logic [W-1:0] v);
    @(negedge clk);
    ld_en = 1; ld_idx = 3'(idx); ld_data = v;
    @(negedge clk);
    ld_en = 0;
    m[idx] = v;
  endtask

  // returns 0 bad, 1 single, 2 multiply; updates mirror
  function automatic int model(input logic [7:0] oc, input logic [7:0] mr);
    logic [2:0] s = mr[5:3], r = mr[2:0];
    logic [W-1:0] a = m[r], res;
    logic [4:0] c = m[1][4:0];
    logic [63:0] p;
    if (mr[7:6] != 2'b11) return 0;
    if (oc == 8'hF7) begin
      if (s == 2) begin res = ~a; m[r] = res; msf = res[31]; mzf = (res == 0); mof = 0; return 1; end
      if (s == 3) begin
        if (a == 32'h80000000) begin msf = 1; mzf = 0; mof = 1; end
        else begin res = -a; m[r] = res; msf = res[31]; mzf = (res == 0); mof = 0; end
        return 1;
      end
      if (s == 4) begin
        p = 64'(m[0]) * 64'(a);
        m[0] = p[31:0]; m[2] = p[63:32]; mof = (p[63:32] != 0);
        return 2;
      end
      return 0;
    end
    if (oc == 8'hD3) begin
      if (s == 4) begin res = a << c; if (c == 1) mof = a[31] ^ a[30]; msf = res[31]; end
      else if (s == 5) begin res = a >> c; if (c == 1) mof = a[31]; msf = 0; end
      else if (s == 7) begin res = W'($signed(a) >>> c); if (c == 1) mof = 0; msf = res[31]; end
      else return 0;
      m[r] = res; mzf = (res == 0);
      return 1;
    end
    return 0;
  endfunction

  task automatic run_op(input logic [7:0] oc, input logic [7:0] mr, input string req, input bit poke);
    int k, n;
    k = model(oc, mr);
    @(negedge clk);
    op_valid = 1; op_code = oc; op_modrm = mr;
    @(negedge clk);
    op_valid = 0;
    if (k == 2) begin
      chk({req, " busy"}, W'(busy), 1);
      if (poke) begin
        op_valid = 1; op_code = 8'hF7; op_modrm = 8'hD5;  // R11 NOT on reg 5 while busy
        @(negedge clk);
        op_valid = 0;
        chk("R11 no pulse", W'(done | bad_op), 0);
        n = 1;
      end else n = 0;
      while (!done && n < 100) begin @(negedge clk); n++; end
      chk("R5 latency", W'(n), W);
      chk("R5 done", W'(done), 1);
    end else begin
      chk({req, " done"}, W'(done), W'(k == 1));
      chk({req, " bad_op"}, W'(bad_op), W'(k == 0));
    end
    chk_flags(req);
    chk_regs(req);
    @(negedge clk);
    chk({req, " done one cycle"}, W'(done | bad_op), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", W'(busy), 0);
    chk("R1 done", W'(done), 0);
    chk("R1 bad_op", W'(bad_op), 0);
    chk_flags("R1");
    chk_regs("R1");

    // R12 load and read
    load(3, 32'h0f0f00ff);
    chk_regs("R12");
    // R2 inversion
    run_op(8'hF7, 8'hD3, "R2", 0);
    // R3 negation, incl zero
    load(3, 32'd1);
    run_op(8'hF7, 8'hDB, "R3", 0);
    load(4, 32'd0);
    run_op(8'hF7, 8'hDC, "R3 zero", 0);
    // R4 overflow case
    load(3, 32'h80000000);
    run_op(8'hF7, 8'hDB, "R4", 0);
    // R6 R9 left shift by 1
    load(1, 32'hffffffe1);
    load(3, 32'd13);
    run_op(8'hD3, 8'hE3, "R6", 0);
    load(3, 32'h40000000);
    run_op(8'hD3, 8'hE3, "R9 shl of", 0);
    // R8 arithmetic right
    load(3, 32'hfffffffd);
    run_op(8'hD3, 8'hFB, "R8", 0);
    // R7 logical right, R9 of=bit31
    load(3, 32'hfffffffd);
    run_op(8'hD3, 8'hEB, "R7", 0);
    // R9 overflow held with count 0 and 3; R6 zero count
    load(1, 32'h20);
    load(3, 32'h80000000);
    run_op(8'hD3, 8'hE3, "R9 count0", 0);
    load(1, 32'd3);
    run_op(8'hD3, 8'hFB, "R9 count3", 0);
    // R5 multiply and R11 issue while busy
    load(0, 32'd4); load(1, 32'd3);
    run_op(8'hF7, 8'hE1, "R5", 1);
    load(0, 32'hffffffff); load(6, 32'hffffffff);
    run_op(8'hF7, 8'hE6, "R5 big", 0);
    // R10 rejects
    run_op(8'hF7, 8'hC3, "R10 sel0", 0);
    run_op(8'hD3, 8'hF3, "R10 sel6", 0);
    run_op(8'hF7, 8'h53, "R10 mode", 0);
    run_op(8'h01, 8'hD8, "R10 code", 0);

    // random mix (R13 on every single-cycle op)
    for (int t = 0; t < 400; t++) begin
      int pick;
      logic [7:0] oc, mr;
      if ($urandom_range(0, 3) == 0) load($urandom_range(0, 7), $urandom);
      if ($urandom_range(0, 2) == 0) load(1, 32'($urandom_range(0, 40)));
      pick = $urandom_range(0, 7);
      mr = {2'b11, 3'd0, 3'($urandom_range(0, 7))};
      case (pick)
        0: begin oc = 8'hF7; mr[5:3] = 2; end
        1: begin oc = 8'hF7; mr[5:3] = 3; end
        2: begin oc = 8'hF7; mr[5:3] = 4; end
        3: begin oc = 8'hD3; mr[5:3] = 4; end
        4: begin oc = 8'hD3; mr[5:3] = 5; end
        5: begin oc = 8'hD3; mr[5:3] = 7; end
        6: begin oc = 8'hD3; mr[5:3] = 3'($urandom_range(0, 3)); end
        default: begin oc = 8'($urandom); mr = 8'($urandom); end
      endcase
      run_op(oc, mr, "R13 random", 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule